// File: doc/BRIEF.md
# Reset Sequence Generator

This block turns several reset requests into one timed system reset and controls a shared open-drain reset pad. A power-on reset, a watchdog timeout, a clock-monitor failure or an outside pull-down on the pad each start the same sequence. The sequence is counted on the main clock. The block first pulls the pad low for a fixed drive window. It then lets go of the pad and waits for a fixed release window. Only after that, and only once the pad reads high again, does it drop the internal reset.

The pad level comes back through a synchronizer. An outside device that keeps the pad low past the end of the sequence therefore holds the core in reset for as long as it likes. A small cause register records which request or requests started the most recent sequence. Software clears it with a write-one-to-clear mask. The sequence itself never clears it.

Top module: `rst_seq_gen`

## Requirements
- R1: While `rst_n` is low, and right after the last clock edge at which it was low, `sys_rst` and `pad_drive_en` are 1 and `cause` is 4'b0001. Cause bits: bit 0 power-on, bit 1 watchdog, bit 2 clock monitor, bit 3 pad pulled low from outside.
- R2: Let S be the edge that starts a sequence (for power-on, the last edge with `rst_n` low). `pad_drive_en` is 1 after edges S through S+511 and 0 from edge S+512 on, unless a new sequence starts.
- R3: `sys_rst` is 1 after edges S through S+767. If the synchronized pad reads high at edge S+768, `sys_rst` goes to 0 after that edge.
- R4: A `wdog_req` or `clkmon_req` sampled high at a clock edge makes that edge a new S, in any state, including during an active sequence. The count restarts from zero.
- R5: `pad_in` passes through a two-flop synchronizer. If the pad goes low between edge E and edge E+1 while no sequence is active, the sequence starts at S = E+3.
- R6: A low level on `pad_in` during an active sequence neither starts nor restarts a sequence.
- R7: If the pad is released from outside between edge Q and edge Q+1, `sys_rst` deasserts after edge max(S+768, Q+3).
- R8: At the start edge, `cause` is replaced by the set of sources that started the sequence. Two requests at the same edge set both bits.
- R9: With `cause_clr_we` high, every `cause` bit that is 1 in `cause_clr_mask` is cleared at that edge, and all other bits are kept. If a sequence starts at the same edge, the start wins. Finishing a sequence leaves `cause` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| wdog_req | input | 1 | Watchdog timeout request, synchronous to clk |
| clkmon_req | input | 1 | Clock-monitor failure request, synchronous to clk |
| pad_in | input | 1 | Level read back from the reset pad (asynchronous) |
| cause_clr_we | input | 1 | Write strobe for clearing cause bits |
| cause_clr_mask | input | 4 | Ones select the cause bits to clear |
| pad_drive_en | output | 1 | 1 pulls the reset pad low |
| sys_rst | output | 1 | Internal reset, active high |
| cause | output | 4 | Sources that started the latest sequence |

## Verification
A request seen at an edge takes effect right after that same edge: drive, reset and cause all respond one register stage later. A pad pull-down needs three edges before the sequence starts, two for the synchronizer and one for the controller. A pad release from outside ends the reset three edges after it happens, or at the normal sequence end if that comes later. Each sequence is followed cycle by cycle from its start edge, with both outputs checked at every falling clock edge against these offsets. The cases covered are restart offsets across both windows, release points from before to after the sequence end, and clear strobes that do or do not coincide with a start.

// File: rtl/rsg_pkg.sv
// Package rsg_pkg
// Shared state encoding and cause-bit layout for the reset sequence generator.
// Assumes a single main clock domain for every consumer.
package rsg_pkg;

    // Sequence controller states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DRIVE   = 2'd1,
        ST_RELEASE = 2'd2,
        ST_HOLD    = 2'd3
    } rsg_state_e;

    // Cause register layout
    localparam int CAUSE_W      = 4;
    localparam int CAUSE_POR    = 0;
    localparam int CAUSE_WDOG   = 1;
    localparam int CAUSE_CLKMON = 2;
    localparam int CAUSE_PAD    = 3;

    localparam logic [CAUSE_W-1:0] CAUSE_POR_MASK = CAUSE_W'(1) << CAUSE_POR;

endpackage

// File: rtl/rsg_pad_sync.sv
// Module rsg_pad_sync
// Multi-stage synchronizer for the reset pad level.
// Assumes the pad is low at power-on (the block drives it), so every stage
// resets to 0. STAGES must be at least 2.
module rsg_pad_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_async,
    output logic pad_sync
);

    logic [STAGES-1:0] sync_q;

    // First stage samples the asynchronous pad level
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pad_async;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // Each later stage re-samples the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    endgenerate

    assign pad_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rsg_seq_ctrl.sv
// Module rsg_seq_ctrl
// Phase controller: drive window, release window, then wait for a high pad.
// Assumes restart is synchronous to clk. pad_sync is already synchronized.
// Outputs are registered from the next-state decode, so they do not glitch.
module rsg_seq_ctrl
    import rsg_pkg::*;
#(
    parameter int DRIVE_CYC   = 512,
    parameter int RELEASE_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic pad_sync,
    output logic ext_start,
    output logic drive_en,
    output logic sys_rst
);

    localparam int MAX_CYC = (DRIVE_CYC > RELEASE_CYC) ? DRIVE_CYC : RELEASE_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(DRIVE_CYC - 1);
    localparam logic [CNT_W-1:0] REL_LAST = CNT_W'(RELEASE_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    rsg_state_e       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             drive_q, rst_q;

    // A low pad counts as a request only while no sequence is running
    assign ext_start = (st_q == ST_IDLE) && !pad_sync;

    // Next-state and phase-count decode
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (restart || ext_start) begin
            st_n  = ST_DRIVE;
            cnt_n = '0;
        end else begin
            unique case (st_q)
                ST_DRIVE: begin
                    if (cnt_q == DRV_LAST) begin
                        st_n  = ST_RELEASE;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_q + CNT_ONE;
                    end
                end
                ST_RELEASE: begin
                    if (cnt_q == REL_LAST) begin
                        st_n  = pad_sync ? ST_IDLE : ST_HOLD;
                        cnt_n = '0;
                    end else begin
                        cnt_n = cnt_q + CNT_ONE;
                    end
                end
                ST_HOLD: begin
                    if (pad_sync) st_n = ST_IDLE;
                end
                default: begin
                    st_n = ST_IDLE;
                end
            endcase
        end
    end

    // State, counter and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_DRIVE;
            cnt_q   <= '0;
            drive_q <= 1'b1;
            rst_q   <= 1'b1;
        end else begin
            st_q    <= st_n;
            cnt_q   <= cnt_n;
            drive_q <= (st_n == ST_DRIVE);
            rst_q   <= (st_n != ST_IDLE);
        end
    end

    assign drive_en = drive_q;
    assign sys_rst  = rst_q;

endmodule

// File: rtl/rsg_cause_reg.sv
// Module rsg_cause_reg
// Holds the sources that started the latest sequence; write-one-to-clear.
// Assumes hit is a one-cycle vector of the sources that start a sequence at
// this edge. A start takes precedence over a clear at the same edge.
module rsg_cause_reg
    import rsg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] hit,
    input  logic               clr_we,
    input  logic [CAUSE_W-1:0] clr_mask,
    output logic [CAUSE_W-1:0] cause
);

    logic [CAUSE_W-1:0] cause_q;

    // Power-on sets the power-on bit; a start replaces; a clear strobe masks
    always_ff @(posedge clk) begin
        if (!rst_n)       cause_q <= CAUSE_POR_MASK;
        else if (|hit)    cause_q <= hit;
        else if (clr_we)  cause_q <= cause_q & ~clr_mask;
    end

    assign cause = cause_q;

endmodule

// File: rtl/rst_seq_gen.sv
// Module rst_seq_gen
// Reset sequence generator: combines the reset requests, times the pad drive
// and release windows, stretches the internal reset while the pad is held low,
// and records the starting cause.
// Assumes wdog_req, clkmon_req and the clear port are synchronous to clk.
// pad_in may be asynchronous.
module rst_seq_gen
    import rsg_pkg::*;
#(
    parameter int DRIVE_CYC   = 512,
    parameter int RELEASE_CYC = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wdog_req,
    input  logic               clkmon_req,
    input  logic               pad_in,
    input  logic               cause_clr_we,
    input  logic [CAUSE_W-1:0] cause_clr_mask,
    output logic               pad_drive_en,
    output logic               sys_rst,
    output logic [CAUSE_W-1:0] cause
);

    logic               pad_sync;
    logic               ext_start;
    logic               int_restart;
    logic [CAUSE_W-1:0] src_hit;

    assign int_restart = wdog_req | clkmon_req;

    // Collect the sources that start a sequence at this edge
    always_comb begin
        src_hit               = '0;
        src_hit[CAUSE_WDOG]   = wdog_req;
        src_hit[CAUSE_CLKMON] = clkmon_req;
        src_hit[CAUSE_PAD]    = ext_start;
    end

    rsg_pad_sync #(
        .STAGES (SYNC_STAGES)
    ) i_pad_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_async (pad_in),
        .pad_sync  (pad_sync)
    );

    rsg_seq_ctrl #(
        .DRIVE_CYC   (DRIVE_CYC),
        .RELEASE_CYC (RELEASE_CYC)
    ) i_seq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (int_restart),
        .pad_sync  (pad_sync),
        .ext_start (ext_start),
        .drive_en  (pad_drive_en),
        .sys_rst   (sys_rst)
    );

    rsg_cause_reg i_cause_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (src_hit),
        .clr_we   (cause_clr_we),
        .clr_mask (cause_clr_mask),
        .cause    (cause)
    );

endmodule

// File: rtl/rst_seq_gen_chk.sv
// Module rst_seq_gen_chk
// Assertion checker for rst_seq_gen, attached with bind.
// Assumes the parameters match the bound instance.
module rst_seq_gen_chk
    import rsg_pkg::*;
#(
    parameter int DRIVE_CYC   = 512,
    parameter int RELEASE_CYC = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wdog_req,
    input logic               clkmon_req,
    input logic               cause_clr_we,
    input logic               pad_drive_en,
    input logic               sys_rst,
    input logic               pad_sync,
    input logic [CAUSE_W-1:0] cause
);

    localparam int TOTAL = DRIVE_CYC + RELEASE_CYC;

    logic [31:0] drive_run;
    logic [31:0] rst_run;

    // Length of the current drive window since the last request
    always_ff @(posedge clk) begin
        if (!rst_n)                        drive_run <= '0;
        else if (wdog_req || clkmon_req)   drive_run <= '0;
        else if (pad_drive_en)             drive_run <= drive_run + 32'd1;
        else                               drive_run <= '0;
    end

    // Length of the current internal reset, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                         rst_run <= '0;
        else if (!sys_rst)                  rst_run <= '0;
        else if (rst_run < 32'(TOTAL))      rst_run <= rst_run + 32'd1;
    end

    p_drive_in_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pad_drive_en |-> sys_rst);

    p_drive_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        drive_run <= 32'(DRIVE_CYC));

    p_min_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> (rst_run >= 32'(TOTAL)));

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_req || clkmon_req) |=> (pad_drive_en && sys_rst));

    p_exit_pad_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst) |-> $past(pad_sync));

    p_wdog_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_req |=> cause[CAUSE_WDOG]);

    p_cause_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst && !wdog_req && !clkmon_req && !cause_clr_we) |=> $stable(cause));

endmodule

bind rst_seq_gen rst_seq_gen_chk #(
    .DRIVE_CYC   (DRIVE_CYC),
    .RELEASE_CYC (RELEASE_CYC)
) i_rst_seq_gen_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdog_req     (wdog_req),
    .clkmon_req   (clkmon_req),
    .cause_clr_we (cause_clr_we),
    .pad_drive_en (pad_drive_en),
    .sys_rst      (sys_rst),
    .pad_sync     (pad_sync),
    .cause        (cause)
);

// File: tb/test_rst_seq_gen.sv
`timescale 1ns/1ps
module test_rst_seq_gen;

    localparam int DRV = 512;
    localparam int TOT = 768;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdog_req = 1'b0;
    logic       clkmon_req = 1'b0;
    logic       ext_low = 1'b0;
    logic       cause_clr_we = 1'b0;
    logic [3:0] cause_clr_mask = 4'd0;
    logic       pad_in;
    logic       pad_drive_en;
    logic       sys_rst;
    logic [3:0] cause;

    int n_tot  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    // Open-drain pad: low if either side pulls it
    assign pad_in = !(pad_drive_en || ext_low);

    rst_seq_gen i_rst_seq_gen (
        .clk            (clk),
        .rst_n          (rst_n),
        .wdog_req       (wdog_req),
        .clkmon_req     (clkmon_req),
        .pad_in         (pad_in),
        .cause_clr_we   (cause_clr_we),
        .cause_clr_mask (cause_clr_mask),
        .pad_drive_en   (pad_drive_en),
        .sys_rst        (sys_rst),
        .cause          (cause)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tot++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Follow a sequence from offset j0 to stop_j after the start edge
    task automatic follow(input int rst_end, input int on_j, input int off_j,
                          input int j0, input int stop_j, input string tag);
        for (int j = j0; j <= stop_j; j++) begin
            chk(pad_drive_en == (j < DRV), "R2", int'(pad_drive_en), int'(j < DRV));
            chk(sys_rst == (j < rst_end), tag, int'(sys_rst), int'(j < rst_end));
            if (j == on_j)  ext_low = 1'b1;
            if (j == off_j) ext_low = 1'b0;
            if (j < stop_j) step(1);
        end
    endtask

    task automatic req_pulse(input bit w, input bit c);
        wdog_req   = w;
        clkmon_req = c;
        step(1);
        wdog_req   = 1'b0;
        clkmon_req = 1'b0;
    endtask

    // Pad pulled low from idle: start after three edges (R5)
    task automatic ext_begin();
        ext_low = 1'b1;
        step(1);
        chk(sys_rst == 1'b0, "R5", int'(sys_rst), 0);
        step(1);
        chk(sys_rst == 1'b0, "R5", int'(sys_rst), 0);
        step(1);
        chk(sys_rst == 1'b1, "R5", int'(sys_rst), 1);
        chk(cause == 4'b1000, "R8", int'(cause), 8);
    endtask

    initial begin
        int offs[8];
        offs = '{0, 1, 255, 511, 512, 600, 766, 767};

        // R1: power-on state
        step(4);
        chk(sys_rst == 1'b1, "R1", int'(sys_rst), 1);
        chk(pad_drive_en == 1'b1, "R1", int'(pad_drive_en), 1);
        chk(cause == 4'b0001, "R1", int'(cause), 1);
        rst_n = 1'b1;
        follow(TOT, -1, -1, 0, TOT + 2, "R3");
        chk(cause == 4'b0001, "R9", int'(cause), 1);

        // R4, R8: watchdog from idle, cause kept after completion (R9)
        req_pulse(1'b1, 1'b0);
        chk(cause == 4'b0010, "R8", int'(cause), 2);
        follow(TOT, -1, -1, 0, TOT + 2, "R3");
        chk(cause == 4'b0010, "R9", int'(cause), 2);

        // R4: restarts at a sweep of offsets in both windows
        for (int k = 0; k < 8; k++) begin
            req_pulse(1'b1, 1'b0);
            follow(TOT, -1, -1, 0, offs[k], "R4");
            req_pulse(k[0] == 1'b0, k[0] == 1'b1);
            chk(cause == ((k[0] == 1'b0) ? 4'b0010 : 4'b0100), "R8", int'(cause),
                (k[0] == 1'b0) ? 2 : 4);
            follow(TOT, -1, -1, 0, TOT + 2, "R4");
        end

        // R8: simultaneous requests set both bits
        req_pulse(1'b1, 1'b1);
        chk(cause == 4'b0110, "R8", int'(cause), 6);
        follow(TOT, -1, -1, 0, TOT + 2, "R3");

        // R6: pad pulses during drive and release windows are ignored
        req_pulse(1'b1, 1'b0);
        follow(TOT, 100, 110, 0, 400, "R6");
        follow(TOT, 520, 530, 400, TOT + 2, "R6");
        chk(cause == 4'b0010, "R6", int'(cause), 2);

        // R5, R7: pad-started sequence, sweep of outside release points
        for (int r = 760; r <= 776; r++) begin
            int e;
            e = (r + 3 > TOT) ? r + 3 : TOT;
            ext_begin();
            follow(e, -1, r, 0, e + 2, "R7");
        end
        ext_begin();
        follow(TOT, -1, 300, 0, TOT + 2, "R7");

        // R9: write-one-to-clear
        cause_clr_we = 1'b1; cause_clr_mask = 4'b0111;
        step(1);
        cause_clr_we = 1'b0;
        chk(cause == 4'b1000, "R9", int'(cause), 8);
        cause_clr_we = 1'b1; cause_clr_mask = 4'b1000;
        step(1);
        cause_clr_we = 1'b0;
        chk(cause == 4'b0000, "R9", int'(cause), 0);
        cause_clr_we = 1'b1; cause_clr_mask = 4'b1111;
        req_pulse(1'b1, 1'b0);
        cause_clr_we = 1'b0;
        chk(cause == 4'b0010, "R9", int'(cause), 2);
        follow(TOT, -1, -1, 0, TOT + 2, "R3");

        // R4: restart while stretched by a held pad
        ext_begin();
        follow(TOT + 100, -1, -1, 0, TOT + 2, "R7");
        req_pulse(1'b0, 1'b1);
        chk(cause == 4'b0100, "R4", int'(cause), 4);
        follow(TOT, -1, 5, 0, TOT + 2, "R4");

        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_tot++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
        $finish;
    end

endmodule